// File: doc/BRIEF.md
# DDR2 Command Sequencer

This block turns a one-at-a-time host request into DDR2 control pin activity: clock enable, chip select, row strobe, column strobe, write enable, bank and address. After reset it runs the power-up sequence on its own. Clock enable is held low for a set number of cycles. It is then raised and NOPs follow for a long, programmable settle count. Only after that does the host see `ready`.

Each accepted request places exactly one command on the pins for one cycle. A programmable number of NOP cycles follows before the next request can be taken. Read and write requests have their column folded around the auto-precharge bit. Load-mode requests to bank 0 or bank 1 update internal copies of the two mode registers. From those copies the block publishes CAS latency, additive latency, read latency, write latency and burst length.

Two request codes put the device into a low-power state: self-refresh or power-down. Any later request takes it out again. The exit raises clock enable and runs a programmable count of NOPs.

Top module: `ddr2_cmd_seq`

## Requirements
- R1: Pin encodings as {cs_n, ras_n, cas_n, we_n}: load mode 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111, deselect 1111. Host `op` codes: 0 load mode, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 self-refresh entry, 7 power-down entry.
- R2: After reset is released, cke stays low with deselect for CKE_LOW_CYC cycles. Then cke is high with NOP for INIT_NOP_CYC cycles. `ready` stays low throughout and goes high in the following cycle.
- R3: A request is taken on a rising edge where `req` and `ready` are both high. Its command appears on the pins in the cycle after that edge, for exactly one cycle.
- R4: After a command is taken, `ready` is low for GAP_CYC cycles, counting the command cycle. The pins carry NOP in each of those cycles except the command cycle.
- R5: For read and write, addr[9:0] = column[9:0] and addr[10] = `ap`. Column bits from 10 upward go to addr[11] and up, and remaining upper addr bits are 0. The column is host_addr[COL_W-1:0], and ba = bank.
- R6: Precharge drives addr[10] = `ap` (1 means all banks), with every other addr bit 0 and ba = bank. Activate drives addr = host_addr and ba = bank. Refresh drives ba = 0 and addr = 0.
- R7: Load mode drives addr = host_addr and ba = bank. Bank 0 updates the mode copy and bank 1 updates the extended copy. Any other bank leaves both copies unchanged.
- R8: `cas_lat` = mode[6:4], `burst_len` = 1 << mode[2:0], `add_lat` = ext[5:3], `rd_lat` = add_lat + cas_lat, and `wr_lat` = add_lat + cas_lat - 1 modulo 16. These values are visible in the cycle after the load.
- R9: Self-refresh entry drives cke low with the refresh encoding for one cycle. The pins then change to deselect with cke still low, and `ready` stays high.
- R10: Power-down entry drives cke low with deselect, and `ready` stays high while the block is in that state.
- R11: A request taken in a low-power state only wakes the block, and its op, bank, address and ap are ignored. cke goes high with NOP for EXIT_CYC cycles with `ready` low, ba and addr keep their earlier values, and `ready` then returns.
- R12: While reset is high: cke = 0, deselect, `ready` = 0, ba = 0, addr = 0, and both mode copies are 0 (burst_len 1, wr_lat 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host request valid |
| op | input | 3 | Request code |
| bank | input | BA_W | Bank for the request |
| host_addr | input | ADDR_W | Row, column or mode value |
| ap | input | 1 | Auto-precharge / precharge-all flag |
| ready | output | 1 | Request can be taken this cycle |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address pins |
| addr | output | ADDR_W | Address pins |
| cas_lat | output | 3 | CAS latency from mode copy |
| add_lat | output | 3 | Additive latency from extended copy |
| rd_lat | output | 4 | Read latency |
| wr_lat | output | 4 | Write latency |
| burst_len | output | 8 | Burst length in beats |

## Verification
The bench shrinks the timing counts to CKE_LOW_CYC=4, INIT_NOP_CYC=6, GAP_CYC=2 and EXIT_CYC=3. With these values the whole power-up sequence can be counted cycle by cycle in a short run. A gap of two leaves a NOP cycle to observe between command and `ready`. The default address width of 14 bits and column width of 11 bits are kept. Column bit 10 then lands on addr[11] and addr[13:12] must be zero, and host address bits above the column are shown to be dropped.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_MODE    = 3'd0,
        OP_REFRESH      = 3'd1,
        OP_PRECHARGE    = 3'd2,
        OP_ACTIVATE     = 3'd3,
        OP_WRITE        = 3'd4,
        OP_READ         = 3'd5,
        OP_SELF_REFRESH = 3'd6,
        OP_POWER_DOWN   = 3'd7
    } host_op_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_LOAD_MODE = 4'b0000;
    localparam cmd_pins_t CMD_REFRESH   = 4'b0001;
    localparam cmd_pins_t CMD_PRECHARGE = 4'b0010;
    localparam cmd_pins_t CMD_ACTIVATE  = 4'b0011;
    localparam cmd_pins_t CMD_WRITE     = 4'b0100;
    localparam cmd_pins_t CMD_READ      = 4'b0101;
    localparam cmd_pins_t CMD_NOP       = 4'b0111;
    localparam cmd_pins_t CMD_DESELECT  = 4'b1111;

    typedef enum logic [2:0] {
        ST_CKE_LOW,
        ST_INIT,
        ST_IDLE,
        ST_GAP,
        ST_SREF,
        ST_PDN,
        ST_EXIT
    } seq_state_t;

    function automatic cmd_pins_t op_to_cmd(input host_op_t o);
        case (o)
            OP_LOAD_MODE: return CMD_LOAD_MODE;
            OP_REFRESH:   return CMD_REFRESH;
            OP_PRECHARGE: return CMD_PRECHARGE;
            OP_ACTIVATE:  return CMD_ACTIVATE;
            OP_WRITE:     return CMD_WRITE;
            OP_READ:      return CMD_READ;
            default:      return CMD_NOP;
        endcase
    endfunction

    function automatic logic is_low_power(input host_op_t o);
        return (o == OP_SELF_REFRESH) || (o == OP_POWER_DOWN);
    endfunction

    function automatic int unsigned max4(input int unsigned a, b, c, d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import ddr2_seq_pkg::*;
#(
    parameter int unsigned CKE_LOW_CYC  = 10,
    parameter int unsigned INIT_NOP_CYC = 80000,
    parameter int unsigned GAP_CYC      = 2,
    parameter int unsigned EXIT_CYC     = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  host_op_t  op,
    output logic      ready,
    output logic      accept,
    output logic      issue,
    output logic      cke,
    output cmd_pins_t cmd
);

    localparam int unsigned CNT_MAX = max4(CKE_LOW_CYC, INIT_NOP_CYC, GAP_CYC, EXIT_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LD_CKE  = CNT_W'(CKE_LOW_CYC);
    localparam logic [CNT_W-1:0] LD_INIT = CNT_W'(INIT_NOP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_EXIT = CNT_W'(EXIT_CYC - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_done;
    logic             cke_q;
    cmd_pins_t        cmd_q;

    assign cnt_done = (cnt == '0);
    assign ready    = (state == ST_IDLE) || (state == ST_SREF) || (state == ST_PDN);
    assign accept   = req && ready;
    assign issue    = accept && (state == ST_IDLE) && !is_low_power(op);
    assign cke      = cke_q;
    assign cmd      = cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CKE_LOW;
            cnt   <= LD_CKE;
            cke_q <= 1'b0;
            cmd_q <= CMD_DESELECT;
        end else begin
            case (state)
                ST_CKE_LOW: begin
                    if (cnt_done) begin
                        state <= ST_INIT;
                        cnt   <= LD_INIT;
                        cke_q <= 1'b1;
                        cmd_q <= CMD_NOP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_INIT, ST_GAP, ST_EXIT: begin
                    cmd_q <= CMD_NOP;
                    if (cnt_done) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_IDLE: begin
                    if (accept) begin
                        case (op)
                            OP_SELF_REFRESH: begin
                                state <= ST_SREF;
                                cke_q <= 1'b0;
                                cmd_q <= CMD_REFRESH;
                            end
                            OP_POWER_DOWN: begin
                                state <= ST_PDN;
                                cke_q <= 1'b0;
                                cmd_q <= CMD_DESELECT;
                            end
                            default: begin
                                state <= ST_GAP;
                                cnt   <= LD_GAP;
                                cmd_q <= op_to_cmd(op);
                            end
                        endcase
                    end else begin
                        cmd_q <= CMD_NOP;
                    end
                end
                ST_SREF, ST_PDN: begin
                    if (accept) begin
                        state <= ST_EXIT;
                        cnt   <= LD_EXIT;
                        cke_q <= 1'b1;
                        cmd_q <= CMD_NOP;
                    end else begin
                        cmd_q <= CMD_DESELECT;
                    end
                end
                default: begin
                    state <= ST_CKE_LOW;
                    cnt   <= LD_CKE;
                    cke_q <= 1'b0;
                    cmd_q <= CMD_DESELECT;
                end
            endcase
        end
    end

    AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_q.cs_n && cmd_q != CMD_NOP) |=> (cmd_q.cs_n || cmd_q == CMD_NOP)); // R3

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (accept && !(state == ST_IDLE && is_low_power(op))) |=> !ready); // R4

    AST_CKE_RISE_NOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_q) |-> (cmd_q == CMD_NOP)); // R2

    AST_CKE_LOW_PINS: assert property (@(posedge clk) disable iff (rst)
        !cke_q |-> (cmd_q.cs_n || cmd_q == CMD_REFRESH)); // R9

endmodule

// File: rtl/seq_addr_fmt.sv
module seq_addr_fmt
    import ddr2_seq_pkg::*;
#(
    parameter int unsigned BA_W   = 3,
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned COL_W  = 11
) (
    input  host_op_t          op,
    input  logic [BA_W-1:0]   bank,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ap,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int unsigned AP_BIT = 10;

    logic [ADDR_W-1:0] col_fold;
    logic [ADDR_W-1:0] pre_word;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_fold
        if (i < AP_BIT) begin : g_low
            assign col_fold[i] = host_addr[i];
        end else if (i == AP_BIT) begin : g_ap
            assign col_fold[i] = ap;
        end else if (i - 1 < COL_W) begin : g_high
            assign col_fold[i] = host_addr[i-1];
        end else begin : g_zero
            assign col_fold[i] = 1'b0;
        end
        if (i == AP_BIT) begin : g_pre_ap
            assign pre_word[i] = ap;
        end else begin : g_pre_zero
            assign pre_word[i] = 1'b0;
        end
    end

    always_comb begin
        ba_o   = bank;
        addr_o = host_addr;
        case (op)
            OP_READ, OP_WRITE: addr_o = col_fold;
            OP_PRECHARGE:      addr_o = pre_word;
            OP_ACTIVATE, OP_LOAD_MODE: addr_o = host_addr;
            default: begin
                ba_o   = '0;
                addr_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/seq_mode_shadow.sv
module seq_mode_shadow #(
    parameter int unsigned BA_W   = 3,
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BA_W-1:0]   bank,
    input  logic [ADDR_W-1:0] data,
    output logic [2:0]        cas_lat,
    output logic [2:0]        add_lat,
    output logic [3:0]        rd_lat,
    output logic [3:0]        wr_lat,
    output logic [7:0]        burst_len
);

    logic [ADDR_W-1:0] mode_q;
    logic [ADDR_W-1:0] ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ext_q  <= '0;
        end else if (load) begin
            if (bank == BA_W'(0)) mode_q <= data;
            if (bank == BA_W'(1)) ext_q  <= data;
        end
    end

    assign cas_lat   = mode_q[6:4];
    assign add_lat   = ext_q[5:3];
    assign burst_len = 8'd1 << mode_q[2:0];
    assign rd_lat    = {1'b0, add_lat} + {1'b0, cas_lat};
    assign wr_lat    = {1'b0, add_lat} + {1'b0, cas_lat} - 4'd1;

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && bank == BA_W'(0)) |=> (cas_lat == $past(data[6:4]))); // R8

    AST_OTHER_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (load && bank > BA_W'(1)) |=> ($stable(cas_lat) && $stable(add_lat) && $stable(burst_len))); // R7

endmodule

// File: rtl/ddr2_cmd_seq.sv
module ddr2_cmd_seq
    import ddr2_seq_pkg::*;
#(
    parameter int unsigned BA_W         = 3,
    parameter int unsigned ADDR_W       = 14,
    parameter int unsigned COL_W        = 11,
    parameter int unsigned CKE_LOW_CYC  = 10,
    parameter int unsigned INIT_NOP_CYC = 80000,
    parameter int unsigned GAP_CYC      = 2,
    parameter int unsigned EXIT_CYC     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [2:0]        op,
    input  logic [BA_W-1:0]   bank,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ap,
    output logic              ready,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        cas_lat,
    output logic [2:0]        add_lat,
    output logic [3:0]        rd_lat,
    output logic [3:0]        wr_lat,
    output logic [7:0]        burst_len
);

    host_op_t          op_e;
    logic              accept;
    logic              issue;
    cmd_pins_t         cmd;
    logic [BA_W-1:0]   ba_n;
    logic [ADDR_W-1:0] addr_n;
    logic [BA_W-1:0]   ba_q;
    logic [ADDR_W-1:0] addr_q;

    assign op_e = host_op_t'(op);

    seq_ctrl #(
        .CKE_LOW_CYC (CKE_LOW_CYC),
        .INIT_NOP_CYC(INIT_NOP_CYC),
        .GAP_CYC     (GAP_CYC),
        .EXIT_CYC    (EXIT_CYC)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .op    (op_e),
        .ready (ready),
        .accept(accept),
        .issue (issue),
        .cke   (cke),
        .cmd   (cmd)
    );

    seq_addr_fmt #(
        .BA_W  (BA_W),
        .ADDR_W(ADDR_W),
        .COL_W (COL_W)
    ) u_fmt (
        .op       (op_e),
        .bank     (bank),
        .host_addr(host_addr),
        .ap       (ap),
        .ba_o     (ba_n),
        .addr_o   (addr_n)
    );

    seq_mode_shadow #(
        .BA_W  (BA_W),
        .ADDR_W(ADDR_W)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .load     (issue && op_e == OP_LOAD_MODE),
        .bank     (bank),
        .data     (host_addr),
        .cas_lat  (cas_lat),
        .add_lat  (add_lat),
        .rd_lat   (rd_lat),
        .wr_lat   (wr_lat),
        .burst_len(burst_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ba_q   <= '0;
            addr_q <= '0;
        end else if (issue) begin
            ba_q   <= ba_n;
            addr_q <= addr_n;
        end
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign ba    = ba_q;
    assign addr  = addr_q;

    AST_AP_IN_A10: assert property (@(posedge clk) disable iff (rst)
        (issue && (op_e == OP_READ || op_e == OP_WRITE)) |=> (addr_q[10] == $past(ap))); // R5

    AST_WAKE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (accept && !issue) |=> ($stable(addr_q) && $stable(ba_q))); // R11

endmodule

// File: tb/ddr2_cmd_seq_test.sv
`timescale 1ns/1ps
module ddr2_cmd_seq_test;

    localparam int GAP  = 2;
    localparam int EXIT = 3;
    localparam int CKEL = 4;
    localparam int INIT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [2:0]  bank = 3'd0;
    logic [13:0] host_addr = 14'd0;
    logic        ap = 1'b0;
    logic        ready, cke, cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [13:0] addr;
    logic [2:0]  cas_lat, add_lat;
    logic [3:0]  rd_lat, wr_lat;
    logic [7:0]  burst_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ddr2_cmd_seq #(
        .BA_W(3), .ADDR_W(14), .COL_W(11),
        .CKE_LOW_CYC(CKEL), .INIT_NOP_CYC(INIT), .GAP_CYC(GAP), .EXIT_CYC(EXIT)
    ) uut (
        .clk(clk), .rst(rst), .req(req), .op(op), .bank(bank), .host_addr(host_addr), .ap(ap),
        .ready(ready), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cas_lat(cas_lat), .add_lat(add_lat), .rd_lat(rd_lat),
        .wr_lat(wr_lat), .burst_len(burst_len)
    );

    // fields: op[41:39] bank[38:36] host_addr[35:22] ap[21] cmd[20:17] ba[16:14] addr[13:0]
    localparam logic [41:0] VEC [0:9] = '{
        {3'd3, 3'd2, 14'h1ABC, 1'b0, 4'b0011, 3'd2, 14'h1ABC},
        {3'd4, 3'd2, 14'h3DA5, 1'b0, 4'b0100, 3'd2, 14'h09A5},
        {3'd5, 3'd2, 14'h0123, 1'b1, 4'b0101, 3'd2, 14'h0523},
        {3'd5, 3'd5, 14'h07FF, 1'b1, 4'b0101, 3'd5, 14'h0FFF},
        {3'd2, 3'd3, 14'h3FFF, 1'b0, 4'b0010, 3'd3, 14'h0000},
        {3'd2, 3'd1, 14'h0000, 1'b1, 4'b0010, 3'd1, 14'h0400},
        {3'd1, 3'd6, 14'h1234, 1'b0, 4'b0001, 3'd0, 14'h0000},
        {3'd4, 3'd0, 14'h0400, 1'b1, 4'b0100, 3'd0, 14'h0C00},
        {3'd0, 3'd0, 14'h0053, 1'b0, 4'b0000, 3'd0, 14'h0053},
        {3'd0, 3'd1, 14'h0018, 1'b0, 4'b0000, 3'd1, 14'h0018}
    };

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] o, input logic [2:0] b, input logic [13:0] a,
                         input logic p, input logic [3:0] ecmd, input logic [2:0] eba,
                         input logic [13:0] ea, input string tag);
        req = 1'b1; op = o; bank = b; host_addr = a; ap = p;
        @(negedge clk);
        req = 1'b0;
        chk("R1 R3 command pins", pins(), ecmd);
        chk({tag, " bank pins"}, ba, eba);
        chk({tag, " address pins"}, addr, ea);
        chk("R4 ready low in command cycle", ready, 1'b0);
        for (int g = 2; g <= GAP; g++) begin
            @(negedge clk);
            chk("R4 ready low in gap", ready, 1'b0);
            chk("R4 NOP in gap", pins(), 4'b0111);
        end
        @(negedge clk);
        chk("R4 ready back after gap", ready, 1'b1);
        chk("R4 NOP after gap", pins(), 4'b0111);
    endtask

    task automatic wake(input logic [13:0] hold_addr, input logic [2:0] hold_ba);
        req = 1'b1; op = 3'd3; bank = 3'd7; host_addr = 14'h3FFF; ap = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R11 cke high on exit", cke, 1'b1);
        chk("R11 NOP on exit", pins(), 4'b0111);
        chk("R11 addr ignored", addr, hold_addr);
        chk("R11 bank ignored", ba, hold_ba);
        chk("R11 ready low on exit", ready, 1'b0);
        for (int g = 2; g <= EXIT; g++) begin
            @(negedge clk);
            chk("R11 ready low in exit", ready, 1'b0);
            chk("R11 NOP in exit", pins(), 4'b0111);
        end
        @(negedge clk);
        chk("R11 ready back", ready, 1'b1);
        chk("R11 cke stays high", cke, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 cke in reset", cke, 1'b0);
        chk("R12 deselect in reset", pins(), 4'b1111);
        chk("R12 ready in reset", ready, 1'b0);
        chk("R12 addr in reset", addr, 14'h0);
        chk("R12 burst_len in reset", burst_len, 8'd1);
        chk("R12 wr_lat in reset", wr_lat, 4'hF);
        rst = 1'b0;
        // R2 power-up
        for (int k = 0; k < CKEL; k++) begin
            @(negedge clk);
            chk("R2 cke low phase", cke, 1'b0);
            chk("R2 deselect phase", pins(), 4'b1111);
            chk("R2 ready low phase", ready, 1'b0);
        end
        for (int k = 0; k < INIT; k++) begin
            @(negedge clk);
            chk("R2 cke high settle", cke, 1'b1);
            chk("R2 NOP settle", pins(), 4'b0111);
            chk("R2 ready low settle", ready, 1'b0);
        end
        @(negedge clk);
        chk("R2 ready after power-up", ready, 1'b1);

        for (int i = 0; i < 10; i++) begin
            logic [41:0] v;
            string t;
            v = VEC[i];
            case (v[41:39])
                3'd4, 3'd5: t = "R5";
                3'd2, 3'd3, 3'd1: t = "R6";
                default: t = "R7";
            endcase
            issue(v[41:39], v[38:36], v[35:22], v[21], v[20:17], v[16:14], v[13:0], t);
        end

        // R8 latencies from loaded copies (mode 0x53, ext 0x18)
        chk("R8 cas_lat", cas_lat, 3'd5);
        chk("R8 burst_len", burst_len, 8'd8);
        chk("R8 add_lat", add_lat, 3'd3);
        chk("R8 rd_lat", rd_lat, 4'd8);
        chk("R8 wr_lat", wr_lat, 4'd7);

        // R7 load to bank 2 leaves copies alone
        issue(3'd0, 3'd2, 14'h3FFF, 1'b0, 4'b0000, 3'd2, 14'h3FFF, "R7");
        chk("R7 cas_lat unchanged", cas_lat, 3'd5);
        chk("R7 add_lat unchanged", add_lat, 3'd3);
        chk("R7 burst_len unchanged", burst_len, 8'd8);

        // R8 zero latencies, write latency wraps
        issue(3'd0, 3'd0, 14'h0002, 1'b0, 4'b0000, 3'd0, 14'h0002, "R7");
        issue(3'd0, 3'd1, 14'h0000, 1'b0, 4'b0000, 3'd1, 14'h0000, "R7");
        chk("R8 burst_len 4", burst_len, 8'd4);
        chk("R8 rd_lat zero", rd_lat, 4'd0);
        chk("R8 wr_lat wraps", wr_lat, 4'hF);

        // R9 self-refresh entry, then wake
        req = 1'b1; op = 3'd6; bank = 3'd4; host_addr = 14'h1111; ap = 1'b0;
        @(negedge clk);
        req = 1'b0;
        chk("R9 cke low on entry", cke, 1'b0);
        chk("R9 refresh encoding on entry", pins(), 4'b0001);
        chk("R9 ready high", ready, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 cke stays low", cke, 1'b0);
            chk("R9 deselect after entry", pins(), 4'b1111);
            chk("R9 ready stays high", ready, 1'b1);
        end
        wake(14'h0000, 3'd1);

        // R10 power-down entry, then wake
        req = 1'b1; op = 3'd7; bank = 3'd2; host_addr = 14'h2222; ap = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R10 cke low", cke, 1'b0);
            chk("R10 deselect", pins(), 4'b1111);
            chk("R10 ready high", ready, 1'b1);
            @(negedge clk);
        end
        wake(14'h0000, 3'd1);

        // normal command after wake
        issue(3'd5, 3'd7, 14'h03FF, 1'b0, 4'b0101, 3'd7, 14'h03FF, "R5");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule